// File: doc/BRIEF.md
# Quasi-Bidirectional Port Controller

This block controls one byte-wide general purpose I/O port whose pins have no direction register. Each pin's role follows from its latched output bit. A latched 0 turns on a strong pull-down, so the pin is an output driving low. A latched 1 leaves only a weak pull-up, so the pin reads high unless an external device pulls it low, and it then serves as an input.

The processor side changes the output latch with one write strobe and a two-bit operation code. It can replace the latch contents, AND them with a mask, or OR them with a mask. Any latch bit that rises from 0 to 1 on a write gets a strong pull-up for one clock cycle, which shortens the rising edge on the pad. Reads are not latched: they return the pin levels present in the cycle of the read. The pad itself is outside the block and is represented only by three per-bit enable vectors.

Top module: `qbd_port`

## Requirements
- R1: After reset the output latch holds all ones, so `pd_en` is all zeros and `spu_en` is all zeros.
- R2: A write with `wr_op` = 0 (load) replaces the latch with `wr_data`; from the next cycle `pd_en` equals the inverse of that data.
- R3: A write with `wr_op` = 1 (AND) sets the latch to the old latch contents AND `wr_data`.
- R4: A write with `wr_op` = 2 (OR) sets the latch to the old latch contents OR `wr_data`.
- R5: Neither of these changes the latch or raises `spu_en`: a cycle with `wr_en` low, whatever `wr_op` and `wr_data` hold, or a write with `wr_op` = 3.
- R6: Bit i of `pd_en` is 1 exactly when latch bit i is 0, and a bit never has `pd_en` and `spu_en` high together.
- R7: `wpu_en` is all ones in every cycle, reset included.
- R8: In the cycle after a write edge, `spu_en` has a 1 only on the bits that went from 0 to 1 on that write. It falls to 0 the cycle after unless another write raises bits again.
- R9: While `rd_en` is high, `rd_data` equals `pin_lvl` in that same cycle, even when the latch differs. While `rd_en` is low, `rd_data` is zero.
- R10: AND and OR work on the latch and not on the pin levels. A latched 1 on a pin held low from outside stays 1 after an OR with 0 or an AND with 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the output latch |
| wr_op | input | 2 | Operation code: 0 load, 1 AND, 2 OR, 3 no change |
| wr_data | input | 8 | Value or mask for the write |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Pin levels while reading, zero otherwise |
| pin_lvl | input | 8 | Logic levels seen on the pads |
| pd_en | output | 8 | Strong pull-down enable per bit |
| wpu_en | output | 8 | Weak pull-up enable per bit |
| spu_en | output | 8 | Momentary strong pull-up enable per bit |

## Verification
A read and a write can happen in the same cycle. This is where a design could wrongly hand the latch, or the value about to be written, back to the processor instead of the pad levels. The bench raises `rd_en` during a write, with `pin_lvl` set to a pattern unrelated to both the old and the new latch contents, and expects `rd_data` to match `pin_lvl` exactly. A second overlap is back-to-back writes, where one write's boost must be computed against the latch left by the write before it. Both are judged on `pd_en` and `spu_en` at the falling edges after each rising edge.

// File: rtl/qbd_pkg.sv
package qbd_pkg;
    typedef enum logic [1:0] {
        QOP_LOAD = 2'd0,
        QOP_AND  = 2'd1,
        QOP_OR   = 2'd2,
        QOP_HOLD = 2'd3
    } qop_e;
endpackage

// File: rtl/qbd_alu.sv
// Next-latch computation for one write; also reports which bits rise.
module qbd_alu #(
    parameter int WIDTH = 8
) (
    input  logic             en,
    input  logic [1:0]       op,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] mask,
    output logic [WIDTH-1:0] nxt,
    output logic [WIDTH-1:0] rise
);
    import qbd_pkg::*;

    always_comb begin
        nxt = cur;
        if (en) begin
            case (qop_e'(op))
                QOP_LOAD: nxt = mask;
                QOP_AND:  nxt = cur & mask;
                QOP_OR:   nxt = cur | mask;
                default:  nxt = cur;
            endcase
        end
        rise = nxt & ~cur;
    end
endmodule

// File: rtl/qbd_pad_ctl.sv
// Per-bit pad enables derived from the latch and the boost register.
module qbd_pad_ctl #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] latch,
    input  logic [WIDTH-1:0] boost,
    output logic [WIDTH-1:0] pd_en,
    output logic [WIDTH-1:0] wpu_en,
    output logic [WIDTH-1:0] spu_en
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign pd_en[i]  = ~latch[i];
        assign wpu_en[i] = 1'b1;
        assign spu_en[i] = boost[i] & latch[i];
    end
endmodule

// File: rtl/qbd_rd_path.sv
// Unlatched read path: pin levels pass through only while reading.
module qbd_rd_path #(
    parameter int WIDTH = 8
) (
    input  logic             rd_en,
    input  logic [WIDTH-1:0] pin_lvl,
    output logic [WIDTH-1:0] rd_data
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign rd_data[i] = rd_en & pin_lvl[i];
    end
endmodule

// File: rtl/qbd_port.sv
module qbd_port #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_op,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    input  logic [WIDTH-1:0] pin_lvl,
    output logic [WIDTH-1:0] pd_en,
    output logic [WIDTH-1:0] wpu_en,
    output logic [WIDTH-1:0] spu_en
);
    localparam logic [WIDTH-1:0] LATCH_RST = {WIDTH{1'b1}};

    typedef struct packed {
        logic [WIDTH-1:0] latch;
        logic [WIDTH-1:0] boost;
    } state_t;

    state_t st_d, st_q;
    logic [WIDTH-1:0] nxt_w, rise_w;

    qbd_alu #(.WIDTH(WIDTH)) u_alu (
        .en   (wr_en),
        .op   (wr_op),
        .cur  (st_q.latch),
        .mask (wr_data),
        .nxt  (nxt_w),
        .rise (rise_w)
    );

    always_comb begin
        st_d       = st_q;
        st_d.latch = nxt_w;
        st_d.boost = rise_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.latch <= LATCH_RST;
            st_q.boost <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    qbd_pad_ctl #(.WIDTH(WIDTH)) u_pad (
        .latch  (st_q.latch),
        .boost  (st_q.boost),
        .pd_en  (pd_en),
        .wpu_en (wpu_en),
        .spu_en (spu_en)
    );

    qbd_rd_path #(.WIDTH(WIDTH)) u_rd (
        .rd_en   (rd_en),
        .pin_lvl (pin_lvl),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/qbd_port_chk.sv
module qbd_port_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_op,
    input logic [WIDTH-1:0] wr_data,
    input logic             rd_en,
    input logic [WIDTH-1:0] rd_data,
    input logic [WIDTH-1:0] pin_lvl,
    input logic [WIDTH-1:0] pd_en,
    input logic [WIDTH-1:0] wpu_en,
    input logic [WIDTH-1:0] spu_en
);
    AST_LOAD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op == 2'd0) |=> pd_en == ~$past(wr_data)); // R2
    AST_AND_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op == 2'd1) |=> pd_en == ($past(pd_en) | ~$past(wr_data))); // R3
    AST_OR_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op == 2'd2) |=> pd_en == ($past(pd_en) & ~$past(wr_data))); // R4
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || wr_op == 2'd3) |=> ($stable(pd_en) && spu_en == '0)); // R5
    AST_NO_DRIVE_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_en & spu_en) == '0); // R6
    AST_WEAK_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
        wpu_en == {WIDTH{1'b1}}); // R7
    AST_BOOST_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> spu_en == ($past(pd_en) & ~pd_en)); // R8
    AST_READ_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> rd_data == pin_lvl); // R9
    AST_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> rd_data == '0); // R9
endmodule

bind qbd_port qbd_port_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_op   (wr_op),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .pin_lvl (pin_lvl),
    .pd_en   (pd_en),
    .wpu_en  (wpu_en),
    .spu_en  (spu_en)
);

// File: tb/sim_qbd_port.sv
`timescale 1ns/1ps
module sim_qbd_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_op = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] pin_lvl = 8'h00;
    logic [7:0] rd_data, pd_en, wpu_en, spu_en;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    qbd_port u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_op(wr_op),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .pin_lvl(pin_lvl), .pd_en(pd_en), .wpu_en(wpu_en), .spu_en(spu_en)
    );

    // entry: op[25:24] data[23:16] expected pd_en[15:8] expected spu_en[7:0]
    localparam int NVEC = 8;
    localparam logic [25:0] VEC [NVEC] = '{
        {2'd0, 8'h00, 8'hFF, 8'h00},
        {2'd2, 8'h0F, 8'hF0, 8'h0F},
        {2'd1, 8'h3C, 8'hF3, 8'h00},
        {2'd0, 8'hA5, 8'h5A, 8'hA1},
        {2'd3, 8'hFF, 8'h5A, 8'h00},
        {2'd2, 8'h5A, 8'h00, 8'h5A},
        {2'd1, 8'h00, 8'hFF, 8'h00},
        {2'd0, 8'h81, 8'h7E, 8'h81}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // One write cycle; returns at the falling edge after the capturing edge.
    task automatic do_write(input logic [1:0] op, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_op = op; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        #(20 * 5000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 / R7 reset state
        chk("R1 pd_en in reset", pd_en, 8'h00);
        chk("R1 spu_en in reset", spu_en, 8'h00);
        chk("R7 wpu_en in reset", wpu_en, 8'hFF);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pd_en after reset", pd_en, 8'h00);
        chk("R9 rd_data idle", rd_data, 8'h00);

        // R2 R3 R4 R5 R8 vector walk
        for (int k = 0; k < NVEC; k++) begin
            do_write(VEC[k][25:24], VEC[k][23:16]);
            chk($sformatf("R2/R3/R4/R5 vec %0d pd_en", k), pd_en, VEC[k][15:8]);
            chk($sformatf("R8 vec %0d spu_en", k), spu_en, VEC[k][7:0]);
            chk($sformatf("R6 vec %0d overlap", k), pd_en & spu_en, 8'h00);
            @(negedge clk);
            chk($sformatf("R8 vec %0d spu_en cleared", k), spu_en, 8'h00);
        end

        // R5: strobe low with a load pending on the bus, latch stays 81
        @(negedge clk);
        wr_en = 1'b0; wr_op = 2'd0; wr_data = 8'h00;
        @(negedge clk);
        chk("R5 no strobe pd_en", pd_en, 8'h7E);
        chk("R5 no strobe spu_en", spu_en, 8'h00);

        // R9 read in the same cycle as a write; pins unrelated to latch
        @(negedge clk);
        pin_lvl = 8'h3C; rd_en = 1'b1;
        wr_en = 1'b1; wr_op = 2'd0; wr_data = 8'hFF;
        #1 chk("R9 read during write", rd_data, 8'h3C);
        @(negedge clk);
        wr_en = 1'b0;
        chk("R9 read after write", rd_data, 8'h3C);
        chk("R2 load FF pd_en", pd_en, 8'h00);
        chk("R8 load FF boost", spu_en, 8'h7E);
        rd_en = 1'b0;
        #1 chk("R9 rd_data zero when not reading", rd_data, 8'h00);

        // R10: pins held low externally, latch at FF
        pin_lvl = 8'h00; rd_en = 1'b1;
        #1 chk("R10 pins read low", rd_data, 8'h00);
        do_write(2'd2, 8'h00);
        chk("R10 OR 00 keeps latch", pd_en, 8'h00);
        do_write(2'd1, 8'hFF);
        chk("R10 AND FF keeps latch", pd_en, 8'h00);
        chk("R10 no boost", spu_en, 8'h00);
        rd_en = 1'b0;

        // R8 back-to-back writes
        @(negedge clk);
        wr_en = 1'b1; wr_op = 2'd0; wr_data = 8'h00;
        @(negedge clk);
        chk("R8 b2b first spu_en", spu_en, 8'h00);
        chk("R6 b2b first pd_en", pd_en, 8'hFF);
        wr_data = 8'hF0;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R8 b2b second spu_en", spu_en, 8'hF0);
        chk("R6 b2b second pd_en", pd_en, 8'h0F);
        @(negedge clk);
        chk("R8 b2b spu_en falls", spu_en, 8'h00);
        chk("R7 wpu_en running", wpu_en, 8'hFF);

        // R1 reset again restores all ones
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 re-reset pd_en", pd_en, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule